// File: doc/BRIEF.md
# Cascaded Audio Clock Divider

This block turns one module clock into the three clocks a serial audio link needs. A master clock is divided down from the module clock. A bit clock is divided down from that master clock. A frame clock is then counted out from bit-clock falling edges. Both divide ratios are picked by small codes, and some ratios are not powers of two (6, 12 and 24). This lets one module clock per rate family (22.5792 MHz or 24.576 MHz) serve every supported oversampling ratio (128 to 768 times the sample rate).

Everything runs on the module clock. Each stage advances only when the stage before it reports an edge, so all three outputs stay phase-aligned. Software picks the codes so that the bit-clock ratio equals the oversampling ratio divided by twice the word size. A new code is taken up only at the end of an output period. Codes can therefore be rewritten while the clocks run.

Top module: `audio_clk_chain`

## Requirements
- R1: The master-clock code in `div_cfg_i[3:0]` selects division of the module clock by 1, 2, 4, 6, 8, 12, 16 or 24 for codes 0 to 7. For every even ratio N, `mclk_o` is high for N/2 and low for N/2 module-clock cycles.
- R2: With master-clock code 0 and the output enabled, `mclk_o` follows the module clock itself (high while `clk_i` is high, low while it is low).
- R3: The bit-clock code in `div_cfg_i[6:4]` selects division of the master clock by 2, 4, 6, 8, 12 or 16 for codes 0 to 5. `bclk_o` is high and low for half that many master-clock periods each, and it changes only at a master-clock rising edge.
- R4: `lrclk_o` toggles after every `word_bits_i` bit-clock periods, always together with a bit-clock falling edge, so one frame spans twice the word size in bit-clock periods.
- R5: `div_cfg_i[7]` low forces `mclk_o` low while `bclk_o` and `lrclk_o` keep running at their programmed rates.
- R6: Master-clock codes 8 to 15 hold `mclk_o` low, and `bclk_o` and `lrclk_o` then make no edges.
- R7: Bit-clock codes 6 and 7 hold `bclk_o` low, and `lrclk_o` then makes no edges.
- R8: A word size of 0 holds `lrclk_o` low from the next frame boundary on.
- R9: A new divider code or word size takes effect only at the end of the current output period (after its low phase). No high or low pulse is shorter than the smaller of the old and new half periods.
- R10: While reset is asserted all three outputs are low, whatever the configuration inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock; every register of the block runs on it |
| rst_ni | input | 1 | Active-low synchronous reset |
| div_cfg_i | input | 8 | Divider word: bit 7 master-clock output enable, bits 6:4 bit-clock code, bits 3:0 master-clock code |
| word_bits_i | input | WORD_W (6) | Bits per channel word; 0 holds the frame clock low |
| mclk_o | output | 1 | Audio master clock |
| bclk_o | output | 1 | Serial bit clock |
| lrclk_o | output | 1 | Frame (left/right) clock |

## Verification
The bench measures high and low times in module-clock cycles over random and directed code combinations. A wrong ratio entry, or an odd split between the phases, shows up as an off-count pulse. It also watches the edge relations: a bit clock that moves on a master-clock falling edge, or a frame clock that moves on a bit-clock rising edge, would break the cascade. Divider codes are rewritten mid-period, and any runt pulse is caught, because a design that loads a code immediately would cut a phase short. Reserved codes, a zero word size and the disabled master clock are each held over a window. Any stray edge, or any downstream clock that stops, is reported.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    // Widest half-period count used by either divider stage (max 12).
    localparam int HALF_W   = 4;
    localparam int MCODE_W  = 4;
    localparam int BCODE_W  = 3;
    localparam int CFG_W    = 8;

    // Divider word layout (software-visible positions).
    localparam int OE_BIT     = 7;
    localparam int BCODE_LSB  = 4;
    localparam int MCODE_LSB  = 0;

    // Selected divide setting for one even divider stage.
    typedef struct packed {
        logic              ok;    // code is defined
        logic              pass;  // ratio 1: stage follows its source
        logic [HALF_W-1:0] half;  // half period in source ticks
    } div_sel_t;

    function automatic div_sel_t decode_mclk(input logic [MCODE_W-1:0] code);
        div_sel_t s;
        s = '{ok: 1'b1, pass: 1'b0, half: '0};
        case (code)
            4'd0:    s.pass = 1'b1;
            4'd1:    s.half = 4'd1;
            4'd2:    s.half = 4'd2;
            4'd3:    s.half = 4'd3;
            4'd4:    s.half = 4'd4;
            4'd5:    s.half = 4'd6;
            4'd6:    s.half = 4'd8;
            4'd7:    s.half = 4'd12;
            default: s.ok   = 1'b0;
        endcase
        return s;
    endfunction

    function automatic div_sel_t decode_bclk(input logic [BCODE_W-1:0] code);
        div_sel_t s;
        s = '{ok: 1'b1, pass: 1'b0, half: '0};
        case (code)
            3'd0:    s.half = 4'd1;
            3'd1:    s.half = 4'd2;
            3'd2:    s.half = 4'd3;
            3'd3:    s.half = 4'd4;
            3'd4:    s.half = 4'd6;
            3'd5:    s.half = 4'd8;
            default: s.ok   = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/aclk_even_div.sv
// Even-ratio divider advanced by a source tick; the setting is loaded only
// at the end of a low phase (or at once while idle or in pass mode).
module aclk_even_div
    import aclk_pkg::*;
#(
    parameter int CNT_W = aclk_pkg::HALF_W
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     en_i,
    input  div_sel_t sel_i,
    output logic     lvl_o,
    output logic     pass_o,
    output logic     ok_o,
    output logic     rise_o,
    output logic     fall_o
);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              lvl;
        logic              ok;
        logic              pass;
        logic [HALF_W-1:0] half;
    } div_state_t;

    div_state_t q, d;
    logic       at_end;
    logic       period_end;

    always_comb begin
        d          = q;
        rise_o     = 1'b0;
        fall_o     = 1'b0;
        at_end     = (CNT_W'(q.half) - 1'b1) == q.cnt;
        period_end = !q.ok || q.pass || (!q.lvl && at_end);
        if (en_i) begin
            if (period_end) begin
                d.ok   = sel_i.ok;
                d.pass = sel_i.pass;
                d.half = sel_i.half;
                d.cnt  = '0;
                d.lvl  = sel_i.ok && !sel_i.pass;
                rise_o = sel_i.ok;
            end else if (at_end) begin
                d.cnt  = '0;
                d.lvl  = 1'b0;
                fall_o = 1'b1;
            end else begin
                d.cnt  = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign lvl_o  = q.lvl;
    assign pass_o = q.ok && q.pass;
    assign ok_o   = q.ok;

    // R1: the phase counter never passes the active half period.
    a_r1_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.ok && !q.pass) |-> (CNT_W'(q.half) > q.cnt));

    // R9: a new ratio always begins with a fresh high phase.
    a_r9_new_ratio_starts_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$stable(q.half) && q.ok && !q.pass) |-> q.lvl);

endmodule

// File: rtl/aclk_frame_gen.sv
// Frame clock: toggles after WORD bit-clock falling edges; the word size is
// taken up at a frame boundary (frame clock going low).
module aclk_frame_gen #(
    parameter int WORD_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              lvl_o
);

    typedef struct packed {
        logic [WORD_W-1:0] cnt;
        logic [WORD_W-1:0] wsz;
        logic              lvl;
    } frm_state_t;

    frm_state_t q, d;

    always_comb begin
        d = q;
        if (en_i) begin
            if (q.wsz == '0) begin
                d.wsz = word_i;
                d.cnt = '0;
                d.lvl = 1'b0;
            end else if (q.cnt == q.wsz - 1'b1) begin
                d.cnt = '0;
                if (q.lvl) begin
                    d.lvl = 1'b0;
                    d.wsz = word_i;
                end else begin
                    d.lvl = 1'b1;
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign lvl_o = q.lvl;

    // R4: word counter stays inside the active word size.
    a_r4_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.wsz != '0) |-> (q.cnt < q.wsz));

    // R8: with no active word size the frame clock rests low.
    a_r8_zero_word_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.wsz == '0) |-> !q.lvl);

endmodule

// File: rtl/audio_clk_chain.sv
module audio_clk_chain
    import aclk_pkg::*;
#(
    parameter int WORD_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CFG_W-1:0]  div_cfg_i,
    input  logic [WORD_W-1:0] word_bits_i,
    output logic              mclk_o,
    output logic              bclk_o,
    output logic              lrclk_o
);

    div_sel_t m_sel, b_sel;
    logic     m_lvl, m_pass, m_ok, m_rise, m_fall;
    logic     b_lvl, b_pass, b_ok, b_rise, b_fall;
    logic     lr_lvl;
    logic     mclk_raw;

    assign m_sel = decode_mclk(div_cfg_i[MCODE_LSB +: MCODE_W]);
    assign b_sel = decode_bclk(div_cfg_i[BCODE_LSB +: BCODE_W]);

    aclk_even_div #(.CNT_W(HALF_W)) u_mclk_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (1'b1),
        .sel_i  (m_sel),
        .lvl_o  (m_lvl),
        .pass_o (m_pass),
        .ok_o   (m_ok),
        .rise_o (m_rise),
        .fall_o (m_fall)
    );

    aclk_even_div #(.CNT_W(HALF_W)) u_bclk_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (m_rise),
        .sel_i  (b_sel),
        .lvl_o  (b_lvl),
        .pass_o (b_pass),
        .ok_o   (b_ok),
        .rise_o (b_rise),
        .fall_o (b_fall)
    );

    aclk_frame_gen #(.WORD_W(WORD_W)) u_frame (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (b_fall),
        .word_i (word_bits_i),
        .lvl_o  (lr_lvl)
    );

    assign mclk_raw = m_pass ? clk_i : m_lvl;
    assign mclk_o   = div_cfg_i[OE_BIT] & mclk_raw;
    assign bclk_o   = b_pass ? mclk_raw : b_lvl;
    assign lrclk_o  = lr_lvl;

    // R3: bit clock moves only when the master clock rises.
    a_r3_bclk_on_mclk_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((b_lvl != $past(b_lvl)) && !m_pass) |-> $rose(m_lvl));

    // R3: a master-clock falling edge never moves the bit clock.
    a_r3_no_bclk_on_mfall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_fall |=> $stable(b_lvl));

    // R3: a bit-clock rising edge never moves the frame clock.
    a_r3_no_lr_on_brise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        b_rise |=> $stable(lr_lvl));

    // R4: frame clock moves only together with a bit-clock falling edge.
    a_r4_lr_on_bclk_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lr_lvl != $past(lr_lvl)) |-> $fell(b_lvl));

    // R6: an undefined master-clock setting keeps the output low.
    a_r6_reserved_mclk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !m_ok |-> !mclk_o);

    // R7: an undefined bit-clock setting keeps the bit clock low.
    a_r7_reserved_bclk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !b_ok |-> !bclk_o);

endmodule

// File: tb/audio_clk_chain_tb_top.sv
module audio_clk_chain_tb_top;

    localparam int WORD_W = 6;
    localparam int TMO    = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        cfg = '0;
    logic [WORD_W-1:0] wbits = '0;
    logic              mclk, bclk, lrclk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    audio_clk_chain #(.WORD_W(WORD_W)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .div_cfg_i   (cfg),
        .word_bits_i (wbits),
        .mclk_o      (mclk),
        .bclk_o      (bclk),
        .lrclk_o     (lrclk)
    );

    // ---------------- expected-value functions ----------------
    function automatic int mratio(input int code);
        case (code)
            0: return 1;  1: return 2;  2: return 4;  3: return 6;
            4: return 8;  5: return 12; 6: return 16; 7: return 24;
            default: return 0;
        endcase
    endfunction

    function automatic int bratio(input int code);
        case (code)
            0: return 2; 1: return 4; 2: return 6;
            3: return 8; 4: return 12; 5: return 16;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] mk_cfg(input bit oe, input int bc, input int mc);
        return {oe, 3'(bc), 4'(mc)};
    endfunction

    function automatic logic sig(input int sel);
        case (sel)
            0: return mclk;
            1: return bclk;
            default: return lrclk;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] c, input int w);
        @(negedge clk);
        cfg   = c;
        wbits = WORD_W'(w);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic measure(input int sel, output int hi, output int lo);
        int   guard;
        logic prev, cur;
        hi = -1; lo = -1; guard = 0;
        @(negedge clk);
        prev = sig(sel);
        while (guard < TMO) begin
            @(negedge clk);
            cur = sig(sel);
            guard++;
            if (!prev && cur) break;
            prev = cur;
        end
        if (guard >= TMO) return;
        hi = 1;
        while (guard < TMO) begin
            @(negedge clk);
            guard++;
            if (sig(sel)) hi++; else break;
        end
        lo = 1;
        while (guard < TMO) begin
            @(negedge clk);
            guard++;
            if (!sig(sel)) lo++; else break;
        end
        if (guard >= TMO) begin hi = -1; lo = -1; end
    endtask

    task automatic observe(input int n, output int m_hi, output int b_hi,
                           output int b_chg, output int lr_hi, output int lr_chg);
        logic pb, pl;
        m_hi = 0; b_hi = 0; b_chg = 0; lr_hi = 0; lr_chg = 0;
        @(negedge clk);
        pb = bclk; pl = lrclk;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (mclk) m_hi++;
            if (bclk) b_hi++;
            if (lrclk) lr_hi++;
            if (bclk != pb) b_chg++;
            if (lrclk != pl) lr_chg++;
            pb = bclk; pl = lrclk;
        end
    endtask

    // ---------------- edge-alignment and runt monitors ----------------
    bit   align_en = 1'b0;
    int   viol_b = 0, viol_l = 0;
    bit   runt_en = 1'b0;
    int   m_run = 0, b_run = 0, m_min = 1000000, b_min = 1000000;
    logic pm = 1'b0, pb = 1'b0, pl = 1'b0;

    always @(negedge clk) begin
        if (align_en) begin
            if (bclk != pb && !(!pm && mclk)) viol_b++;
            if (lrclk != pl && !(pb && !bclk)) viol_l++;
        end
        if (mclk != pm) begin
            if (runt_en && m_run < m_min) m_min = m_run;
            m_run = 1;
        end else m_run++;
        if (bclk != pb) begin
            if (runt_en && b_run < b_min) b_min = b_run;
            b_run = 1;
        end else b_run++;
        pm = mclk; pb = bclk; pl = lrclk;
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int hi, lo, mh, bh, bc, lh, lc, errs;
        void'($urandom(32'd2718));

        // R10: outputs low during reset with passthrough enabled on the inputs
        cfg = mk_cfg(1'b1, 1, 0);
        wbits = 6'd2;
        repeat (4) @(posedge clk);
        #1;
        check(mclk == 1'b0, "R10 mclk in reset", int'(mclk), 0);
        check(bclk == 1'b0, "R10 bclk in reset", int'(bclk), 0);
        check(lrclk == 1'b0, "R10 lrclk in reset", int'(lrclk), 0);

        // R2: master clock follows module clock; bit clock divides it by 4
        do_reset();
        repeat (20) @(negedge clk);
        errs = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1;
            if (mclk !== 1'b1) errs++;
            @(negedge clk); #1;
            if (mclk !== 1'b0) errs++;
        end
        check(errs == 0, "R2 passthrough mismatches", errs, 0);
        measure(1, hi, lo);
        check(hi == 2 && lo == 2, "R3 bclk high (pass)", hi, 2);

        // R1/R3/R4: random configurations
        for (int t = 0; t < 8; t++) begin
            int mc, bc2, w, mr, br;
            mc  = int'($urandom % 5);
            bc2 = int'($urandom % 4);
            w   = 1 + int'($urandom % 8);
            mr  = mratio(mc);
            br  = bratio(bc2);
            apply(mk_cfg(1'b1, bc2, mc), w);
            do_reset();
            repeat (4 * 2 * w * br * mr + 50) @(negedge clk);
            align_en = (mc != 0);
            viol_b = 0; viol_l = 0;
            if (mc != 0) begin
                measure(0, hi, lo);
                check(hi == mr / 2, "R1 mclk high", hi, mr / 2);
                check(lo == mr / 2, "R1 mclk low", lo, mr / 2);
            end
            measure(1, hi, lo);
            check(hi == br * mr / 2, "R3 bclk high", hi, br * mr / 2);
            check(lo == br * mr / 2, "R3 bclk low", lo, br * mr / 2);
            measure(2, hi, lo);
            check(hi == w * br * mr, "R4 lrclk high", hi, w * br * mr);
            check(lo == w * br * mr, "R4 lrclk low", lo, w * br * mr);
            align_en = 1'b0;
            check(viol_b == 0, "R3 bclk edge off mclk rise", viol_b, 0);
            check(viol_l == 0, "R4 lrclk edge off bclk fall", viol_l, 0);
        end

        // R1/R3/R4: largest ratios (24 and 16), one-bit words
        apply(mk_cfg(1'b1, 5, 7), 1);
        do_reset();
        repeat (3200) @(negedge clk);
        measure(0, hi, lo);
        check(hi == 12 && lo == 12, "R1 mclk ratio 24", hi, 12);
        measure(1, hi, lo);
        check(hi == 192 && lo == 192, "R3 bclk ratio 16", hi, 192);
        measure(2, hi, lo);
        check(hi == 384 && lo == 384, "R4 lrclk one-bit word", hi, 384);

        // R5: master clock gated off, bit clock keeps its rate
        apply(mk_cfg(1'b1, 1, 2), 2);
        do_reset();
        repeat (200) @(negedge clk);
        apply(mk_cfg(1'b0, 1, 2), 2);
        observe(200, mh, bh, bc, lh, lc);
        check(mh == 0, "R5 mclk gated high samples", mh, 0);
        check(lc > 0, "R5 lrclk still toggling", lc, 1);
        measure(1, hi, lo);
        check(hi == 8 && lo == 8, "R5 bclk with mclk gated", hi, 8);

        // R6: reserved master-clock code freezes the chain
        apply(mk_cfg(1'b1, 1, 9), 2);
        repeat (20) @(negedge clk);
        observe(300, mh, bh, bc, lh, lc);
        check(mh == 0, "R6 mclk high samples", mh, 0);
        check(bc == 0, "R6 bclk edges", bc, 0);
        check(lc == 0, "R6 lrclk edges", lc, 0);

        // R7: reserved bit-clock code
        apply(mk_cfg(1'b1, 6, 2), 2);
        repeat (50) @(negedge clk);
        observe(300, mh, bh, bc, lh, lc);
        check(bh == 0, "R7 bclk high samples", bh, 0);
        check(lc == 0, "R7 lrclk edges", lc, 0);
        check(mh == 150, "R7 mclk still running", mh, 150);

        // R8: zero word size
        apply(mk_cfg(1'b1, 1, 2), 0);
        repeat (200) @(negedge clk);
        observe(300, mh, bh, bc, lh, lc);
        check(lh == 0, "R8 lrclk high samples", lh, 0);
        check(bc > 0, "R8 bclk still toggling", bc, 1);

        // R9: codes rewritten mid-period, no runt pulses
        apply(mk_cfg(1'b1, 1, 3), 2);
        do_reset();
        repeat (300) @(negedge clk);
        m_min = 1000000; b_min = 1000000;
        runt_en = 1'b1;
        repeat (5) @(negedge clk);
        apply(mk_cfg(1'b1, 0, 3), 2);
        repeat (101) @(negedge clk);
        apply(mk_cfg(1'b1, 3, 3), 2);
        repeat (203) @(negedge clk);
        apply(mk_cfg(1'b1, 3, 4), 2);
        repeat (300) @(negedge clk);
        runt_en = 1'b0;
        check(b_min >= 6, "R9 shortest bclk phase", b_min, 6);
        check(m_min >= 3, "R9 shortest mclk phase", m_min, 3);
        measure(1, hi, lo);
        check(hi == 32 && lo == 32, "R9 bclk after rewrite", hi, 32);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule